// File: doc/BRIEF.md
# Local-Space Pointer Relocation Unit

This unit sits in the address path in front of the memory pipeline. Each request carries a 64-bit program pointer and the 4-bit ID of the protection domain that issued it. The top bit of the pointer, bit 63, is the local flag. When the flag is set, the unit XORs the pointer with that domain's local-space value and clears bit 63 of the result. When the flag is clear, the pointer leaves the unit unchanged as a global address. XOR is used instead of an add because it has no carry chain, so the relocation adds only one gate level to the address path.

The unit holds one local-space value for each of the 16 domains. All values reset to zero, and with a zero value a local pointer and a global pointer name the same place. Supervisory software sets a value through a write port, for example to give a child domain its own window after a process has been duplicated. A write in the same cycle as a request for that domain is forwarded, so the request uses the new value.

The result is registered. A two-state output stage, `ST_IDLE` (empty) and `ST_HOLD` (result waiting), gives a valid/ready handshake on both sides. There are four transitions:
- IDLE→HOLD on accept.
- HOLD→HOLD on accept while draining, or while stalled.
- HOLD→IDLE on drain without accept.
- IDLE→IDLE otherwise.

Top module: `lsr_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and every domain's local-space value is zero, so a local pointer leaves as the pointer with bit 63 cleared.
- R2: A pointer with bit 63 clear comes out on `out_addr` equal to the input pointer.
- R3: A pointer with bit 63 set comes out as (pointer XOR local-space value of `in_dom`) with bit 63 forced to 0. Bit 63 of `out_addr` is therefore always 0.
- R4: Each domain has its own value. A write to one domain does not change the result for any other domain, including a request to another domain in the same cycle.
- R5: When `wr_en` targets the domain of a request accepted in the same cycle, the request uses `wr_val`.
- R6: A request accepted on a clock edge (`in_valid` and `in_ready` both high) shows `out_valid` high after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr` stays stable.
- R8: `in_ready` is high exactly when the output stage is empty or `out_ready` is high.
- R9: A written value persists for later requests until the next write to the same domain replaces it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_ptr | input | 64 | Program pointer; bit 63 is the local flag |
| in_dom | input | 4 | Domain ID of the request |
| out_valid | output | 1 | Effective address present |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | 64 | Global effective address |
| wr_en | input | 1 | Local-space value write strobe |
| wr_dom | input | 4 | Domain whose value is written |
| wr_val | input | 64 | New local-space value |

## Verification
Some properties are checked by assertions on every cycle:
- the handshake timing: accept-to-valid latency, stall stability, and the ready condition;
- pass-through of global pointers;
- bit 63 being cleared in every output;
- the empty output stage after reset.

The XOR against the correct domain's value depends on register contents, so only the bench scenarios can show it. The same holds for same-cycle write forwarding, isolation between domains, and the persistence and overwrite of stored values.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } stage_e;

endpackage

// File: rtl/lsr_regfile.sv
module lsr_regfile #(
    parameter int ADDR_W = 64,
    parameter int DOM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DOM_W-1:0]  wr_dom,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic [DOM_W-1:0]  rd_dom,
    output logic [ADDR_W-1:0] rd_val
);

    localparam int NUM_DOM = 1 << DOM_W;

    logic [NUM_DOM*ADDR_W-1:0] bank_flat;

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        logic [ADDR_W-1:0] space_q;
        logic              hit;

        assign hit = wr_en && (wr_dom == DOM_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                space_q <= '0;
            end else if (hit) begin
                space_q <= wr_val;
            end
        end

        assign bank_flat[g*ADDR_W +: ADDR_W] = space_q;
    end

    // Same-cycle write to the requested domain is forwarded.
    always_comb begin
        if (wr_en && (wr_dom == rd_dom)) begin
            rd_val = wr_val;
        end else begin
            rd_val = bank_flat[rd_dom*ADDR_W +: ADDR_W];
        end
    end

endmodule

// File: rtl/lsr_xform.sv
module lsr_xform #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] space,
    output logic [ADDR_W-1:0] eff
);

    localparam int FLAG_BIT = ADDR_W - 1;

    logic [ADDR_W-1:0] mixed;

    always_comb begin
        mixed           = ptr ^ space;
        mixed[FLAG_BIT] = 1'b0;
        eff = ptr[FLAG_BIT] ? mixed : ptr;
    end

endmodule

// File: rtl/lsr_outstage.sv
module lsr_outstage
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ADDR_W-1:0] dn_data
);

    stage_e state_q, state_d;
    logic   accept;
    logic   drain;

    assign accept = up_valid && up_ready;
    assign drain  = dn_valid && dn_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (drain && !accept) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        dn_valid = 1'b0;
        up_ready = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                dn_valid = 1'b0;
                up_ready = 1'b1;
            end
            ST_HOLD: begin
                dn_valid = 1'b1;
                up_ready = dn_ready;
            end
            default: begin
                dn_valid = 1'b0;
                up_ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_data <= '0;
        end else if (accept) begin
            dn_data <= up_data;
        end
    end

endmodule

// File: rtl/lsr_unit.sv
module lsr_unit #(
    parameter int ADDR_W = 64,
    parameter int DOM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_ptr,
    input  logic [DOM_W-1:0]  in_dom,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    input  logic              wr_en,
    input  logic [DOM_W-1:0]  wr_dom,
    input  logic [ADDR_W-1:0] wr_val
);

    logic [ADDR_W-1:0] space_val;
    logic [ADDR_W-1:0] eff_addr;

    lsr_regfile #(
        .ADDR_W(ADDR_W),
        .DOM_W (DOM_W)
    ) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wr_dom(wr_dom),
        .wr_val(wr_val),
        .rd_dom(in_dom),
        .rd_val(space_val)
    );

    lsr_xform #(
        .ADDR_W(ADDR_W)
    ) u_xform (
        .ptr  (in_ptr),
        .space(space_val),
        .eff  (eff_addr)
    );

    lsr_outstage #(
        .ADDR_W(ADDR_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_valid(in_valid),
        .up_ready(in_ready),
        .up_data (eff_addr),
        .dn_valid(out_valid),
        .dn_ready(out_ready),
        .dn_data (out_addr)
    );

endmodule

// File: rtl/lsr_unit_chk.sv
module lsr_unit_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_ptr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R2
    global_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_ptr[ADDR_W-1]) |=> (out_addr == $past(in_ptr)));

    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_addr[ADDR_W-1]);

    // R6
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    // R8
    ready_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

endmodule

bind lsr_unit lsr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_ptr   (in_ptr),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_addr (out_addr)
);

// File: tb/lsr_unit_tb.sv
`timescale 1ns/1ps
module lsr_unit_tb;

    localparam int ADDR_W = 64;
    localparam int DOM_W  = 4;
    localparam int NUM_DOM = 1 << DOM_W;

    typedef struct packed {
        logic              is_wr;
        logic [DOM_W-1:0]  dom;
        logic [ADDR_W-1:0] data;
    } vec_t;

    // is_wr=1: write data as domain value; is_wr=0: request with pointer data.
    localparam vec_t VECS [12] = '{
        '{1'b1, 4'd1,  64'h0000_0000_0000_0F00},
        '{1'b0, 4'd1,  64'h8000_0000_0000_00F0},  // local, R3
        '{1'b0, 4'd1,  64'h0000_0000_0000_00F0},  // global, R2
        '{1'b1, 4'd2,  64'hFFFF_FFFF_FFFF_FFFF},  // value with bit 63 set
        '{1'b0, 4'd2,  64'h8123_4567_89AB_CDEF},
        '{1'b0, 4'd1,  64'h8000_0000_0000_0F00},
        '{1'b1, 4'd15, 64'h0123_4567_89AB_CDEF},
        '{1'b0, 4'd15, 64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b0, 4'd0,  64'h8000_0000_DEAD_BEEF},  // untouched domain, R4
        '{1'b1, 4'd1,  64'h0000_0000_0000_5555},  // overwrite, R9
        '{1'b0, 4'd1,  64'h8000_0000_0000_0000},
        '{1'b0, 4'd15, 64'h7FFF_FFFF_FFFF_FFFF}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [ADDR_W-1:0] in_ptr = '0;
    logic [DOM_W-1:0]  in_dom = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [ADDR_W-1:0] out_addr;
    logic              wr_en = 1'b0;
    logic [DOM_W-1:0]  wr_dom = '0;
    logic [ADDR_W-1:0] wr_val = '0;

    logic [ADDR_W-1:0] mdl [NUM_DOM];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lsr_unit #(.ADDR_W(ADDR_W), .DOM_W(DOM_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_ptr(in_ptr), .in_dom(in_dom),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .wr_en(wr_en), .wr_dom(wr_dom), .wr_val(wr_val)
    );

    function automatic logic [ADDR_W-1:0] expect_of(logic [ADDR_W-1:0] p, logic [ADDR_W-1:0] s);
        logic [ADDR_W-1:0] r;
        if (p[ADDR_W-1]) begin
            r = p ^ s;
            r[ADDR_W-1] = 1'b0;
        end else begin
            r = p;
        end
        return r;
    endfunction

    task automatic check(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [DOM_W-1:0] d, logic [ADDR_W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_dom = d; wr_val = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        mdl[d] = v;
    endtask

    // Drives a request at a negedge, samples the result one negedge later.
    task automatic do_request(string req, logic [DOM_W-1:0] d, logic [ADDR_W-1:0] p);
        @(negedge clk);
        in_valid = 1'b1; in_dom = d; in_ptr = p; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, ADDR_W'(out_valid), ADDR_W'(1));
        check(req, out_addr, expect_of(p, mdl[d]));
    endtask

    initial begin
        for (int i = 0; i < NUM_DOM; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: empty stage and ready while and after reset
        check("R1 reset out_valid", ADDR_W'(out_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", ADDR_W'(out_valid), '0);
        check("R8 in_ready idle", ADDR_W'(in_ready), ADDR_W'(1));
        // R1: zero value after reset makes local equal to global
        do_request("R1 zero value", 4'd7, 64'h8000_1234_0000_ABCD);
        check("R1 exact", out_addr, 64'h0000_1234_0000_ABCD);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            if (VECS[i].is_wr) begin
                do_write(VECS[i].dom, VECS[i].data);
            end else begin
                do_request(VECS[i].data[ADDR_W-1] ? "R3 local" : "R2 global",
                           VECS[i].dom, VECS[i].data);
            end
        end
        // R9: overwrite took effect on domain 1 (value 0x5555)
        do_request("R9 persist", 4'd1, 64'h8000_0000_0000_FFFF);
        check("R9 exact", out_addr, 64'h0000_0000_0000_AAAA);

        // R5: same-cycle write forwarded to request of that domain
        @(negedge clk);
        wr_en = 1'b1; wr_dom = 4'd6; wr_val = 64'h0000_00FF_0000_0000;
        in_valid = 1'b1; in_dom = 4'd6; in_ptr = 64'h8000_0F00_0000_0001;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; in_valid = 1'b0;
        mdl[6] = 64'h0000_00FF_0000_0000;
        check("R5 forward", out_addr, 64'h0000_0FFF_0000_0001);

        // R4: same-cycle write to domain 3, request to domain 4 uses old zero
        @(negedge clk);
        wr_en = 1'b1; wr_dom = 4'd3; wr_val = 64'h0000_0000_FFFF_0000;
        in_valid = 1'b1; in_dom = 4'd4; in_ptr = 64'h8000_0000_0000_0042;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; in_valid = 1'b0;
        mdl[3] = 64'h0000_0000_FFFF_0000;
        check("R4 other domain", out_addr, 64'h0000_0000_0000_0042);
        do_request("R9 stored", 4'd3, 64'h8000_0000_0000_0042);
        check("R9 stored exact", out_addr, 64'h0000_0000_FFFF_0042);

        // R7/R8: backpressure
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_dom = 4'd1; in_ptr = 64'h8000_0000_0000_0001;
        @(posedge clk);
        @(negedge clk);
        check("R6 valid after accept", ADDR_W'(out_valid), ADDR_W'(1));
        check("R3 held A", out_addr, 64'h0000_0000_0000_5554);
        in_dom = 4'd15; in_ptr = 64'h0000_0000_0000_0777;
        #0.5;
        check("R8 not ready stalled", ADDR_W'(in_ready), '0);
        @(posedge clk);
        @(negedge clk);
        check("R7 still valid", ADDR_W'(out_valid), ADDR_W'(1));
        check("R7 stable", out_addr, 64'h0000_0000_0000_5554);
        out_ready = 1'b1;
        #0.5;
        check("R8 ready on drain", ADDR_W'(in_ready), ADDR_W'(1));
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second after stall", out_addr, 64'h0000_0000_0000_0777);
        @(posedge clk);
        @(negedge clk);
        check("R6 drained", ADDR_W'(out_valid), '0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule